// File: doc/BRIEF.md
# Multi-Size Walsh-Hadamard Reorder Stage

This block transforms a vector of 32 signed samples with an unnormalised Walsh-Hadamard transform of 4, 8, 16 or 32 points, all in a single pass. The transform uses a fully parallel butterfly network. A two-bit size code sets how many of the leading samples take part and how many butterfly levels are active. The same network serves every size: shorter transforms use only the butterflies that sit on the leading lanes.

The network produces its results in natural Hadamard order. Two fixed permutations then rearrange them. The first is a bit-reversal over log2(N) bits and the second is a Gray-code index map. Together they place the basis functions in sequency (Walsh) order, so output lane j holds the coefficient whose basis function changes sign exactly j times.

The result is captured in one output register together with a valid flag. A transform core that goes on to apply rotations and scaling would instantiate this stage at its front.

Top module: `walsh_order_xform`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and every lane of out_data is 0.
- R2: out_valid equals in_valid delayed by exactly one clock cycle.
- R3: out_data is loaded only on a clock edge where in_valid is 1. On every other edge it keeps its value.
- R4: Size code 0, 1, 2 and 3 select N = 4, 8, 16 and 32 points. Input lanes n >= N have no effect on the result.
- R5: Output lanes j >= N are 0.
- R6: For j < N, lane j equals the sum over n < N of x[n]·(−1)^popcount(i AND n), with i = bitrev_L(j XOR (j>>1)) and L = log2(N).
- R7: Lane 0 equals the plain sum of the first N input samples.
- R8: Each output lane is DATA_W+5 bits wide, signed two's complement. Full-scale inputs of either sign give exact results without wrap.
- R9: For a 32-point transform, the basis function seen at lane j has exactly j sign changes across the input index. This is sequency order.
- Lane k of a packed bus occupies bits [k·width +: width], and lane 0 is in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_size | input | 2 | Size code: 0=4, 1=8, 2=16, 3=32 points |
| in_data | input | 32·DATA_W | 32 signed input samples, lane 0 in the LSBs |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 32·(DATA_W+5) | 32 signed coefficients in sequency order |

## Verification
A butterfly level that is enabled for the wrong size shows up in the cycle after capture. It either leaves nonzero values in lanes at or above N, or it leaves lane 0 different from the plain input sum. A wrong permutation entry changes the sign pattern of one lane without changing its magnitude. Impulse inputs expose this at once, because each lane's sign sequence then has the wrong number of transitions. A bad capture enable shows as a changed output on a cycle with no valid input.

// File: rtl/wht_pkg.sv
`timescale 1ns/1ps
package wht_pkg;
  // Reverse the low 'bits' bits of v.
  function automatic int bit_rev(input int v, input int bits);
    int r;
    r = 0;
    for (int b = 0; b < bits; b++) begin
      if (((v >> b) & 1) != 0) r = r | (1 << (bits - 1 - b));
    end
    return r;
  endfunction

  // Binary-reflected Gray code of v.
  function automatic int gray_of(input int v);
    return v ^ (v >> 1);
  endfunction
endpackage

// File: rtl/wht_bfly_level.sv
`timescale 1ns/1ps
// One radix-2 level: lanes paired at distance SPAN, sum into the lower, difference into the upper.
module wht_bfly_level #(
  parameter int LANES = 32,
  parameter int W     = 17,
  parameter int SPAN  = 1
) (
  input  logic                en,
  input  logic signed [W-1:0] a [LANES],
  output logic signed [W-1:0] y [LANES]
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if ((k & SPAN) == 0) begin : g_lo
      assign y[k] = en ? (a[k] + a[k+SPAN]) : a[k];
    end else begin : g_hi
      assign y[k] = en ? (a[k-SPAN] - a[k]) : a[k];
    end
  end
endmodule

// File: rtl/wht_net.sv
`timescale 1ns/1ps
// Parallel natural-order Hadamard network; levels beyond log2(N) pass data through.
module wht_net #(
  parameter int LANES = 32,
  parameter int W     = 17,
  localparam int LOGL = $clog2(LANES)
) (
  input  logic [$clog2(LOGL+1)-1:0] log_n,
  input  logic signed [W-1:0]       x [LANES],
  output logic signed [W-1:0]       h [LANES]
);
  logic signed [W-1:0] st [LOGL+1][LANES];

  for (genvar n = 0; n < LANES; n++) begin : g_mask
    assign st[0][n] = (n < (1 << log_n)) ? x[n] : '0;
  end

  for (genvar s = 0; s < LOGL; s++) begin : g_lvl
    wht_bfly_level #(.LANES(LANES), .W(W), .SPAN(1 << s)) u_lvl (
      .en (s < int'(log_n)),
      .a  (st[s]),
      .y  (st[s+1])
    );
  end

  assign h = st[LOGL];
endmodule

// File: rtl/walsh_reorder.sv
`timescale 1ns/1ps
// Bit-reversal then Gray-code gather, built per size and chosen by the size code.
module walsh_reorder #(
  parameter int LANES = 32,
  parameter int W     = 17,
  localparam int LOGL  = $clog2(LANES),
  localparam int NSIZE = LOGL - 1,
  localparam int SZ_W  = $clog2(NSIZE)
) (
  input  logic [SZ_W-1:0]     size,
  input  logic signed [W-1:0] h [LANES],
  output logic signed [W-1:0] y [LANES]
);
  logic signed [W-1:0] br [NSIZE][LANES];
  logic signed [W-1:0] gy [NSIZE][LANES];

  for (genvar c = 0; c < NSIZE; c++) begin : g_size
    localparam int L = c + 2;
    localparam int N = 1 << L;
    for (genvar k = 0; k < LANES; k++) begin : g_k
      if (k < N) begin : g_on
        assign br[c][k] = h[wht_pkg::bit_rev(k, L)];
        assign gy[c][k] = br[c][wht_pkg::gray_of(k)];
      end else begin : g_off
        assign br[c][k] = '0;
        assign gy[c][k] = '0;
      end
    end
  end

  always_comb begin
    y = gy[NSIZE-1];
    for (int c = 0; c < NSIZE; c++) begin
      if (int'(size) == c) y = gy[c];
    end
  end
endmodule

// File: rtl/walsh_order_xform.sv
`timescale 1ns/1ps
module walsh_order_xform #(
  parameter int LANES  = 32,
  parameter int DATA_W = 12,
  localparam int LOGL  = $clog2(LANES),
  localparam int OUT_W = DATA_W + LOGL,
  localparam int SZ_W  = $clog2(LOGL - 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [SZ_W-1:0]        in_size,
  input  logic [LANES*DATA_W-1:0] in_data,
  output logic                   out_valid,
  output logic [LANES*OUT_W-1:0] out_data
);
  logic signed [OUT_W-1:0] x_ext [LANES];
  logic signed [OUT_W-1:0] h_nat [LANES];
  logic signed [OUT_W-1:0] y_seq [LANES];
  logic [LANES*OUT_W-1:0]  y_flat;
  logic [$clog2(LOGL+1)-1:0] log_n;

  assign log_n = $clog2(LOGL+1)'(in_size) + $clog2(LOGL+1)'(2);

  for (genvar n = 0; n < LANES; n++) begin : g_in
    assign x_ext[n] = {{(OUT_W-DATA_W){in_data[n*DATA_W+DATA_W-1]}},
                       in_data[n*DATA_W +: DATA_W]};
    assign y_flat[n*OUT_W +: OUT_W] = y_seq[n];
  end

  wht_net #(.LANES(LANES), .W(OUT_W)) u_net (
    .log_n (log_n),
    .x     (x_ext),
    .h     (h_nat)
  );

  walsh_reorder #(.LANES(LANES), .W(OUT_W)) u_reorder (
    .size (in_size),
    .h    (h_nat),
    .y    (y_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= y_flat;
    end
  end
endmodule

// File: rtl/walsh_order_xform_chk.sv
`timescale 1ns/1ps
module walsh_order_xform_chk #(
  parameter int LANES  = 32,
  parameter int DATA_W = 12,
  localparam int LOGL  = $clog2(LANES),
  localparam int OUT_W = DATA_W + LOGL,
  localparam int SZ_W  = $clog2(LOGL - 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [SZ_W-1:0]         in_size,
  input logic [LANES*DATA_W-1:0] in_data,
  input logic                    out_valid,
  input logic [LANES*OUT_W-1:0]  out_data
);
  logic signed [OUT_W-1:0] dc_sum;
  logic [SZ_W-1:0]         sz_q;
  logic                    upper_bad;

  always_comb begin
    dc_sum = '0;
    for (int n = 0; n < LANES; n++) begin
      if (n < (4 << in_size))
        dc_sum = dc_sum + OUT_W'($signed(in_data[n*DATA_W +: DATA_W]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sz_q <= '1;
    else if (in_valid) sz_q <= in_size;
  end

  always_comb begin
    upper_bad = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (j >= (4 << sz_q) && out_data[j*OUT_W +: OUT_W] != '0) upper_bad = 1'b1;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data)); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) !upper_bad); // R5
  AST_DC_LANE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($signed(out_data[OUT_W-1:0]) == $past(dc_sum))); // R7
endmodule

bind walsh_order_xform walsh_order_xform_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/walsh_order_xform_bench.sv
`timescale 1ns/1ps
module walsh_order_xform_bench;
  localparam int LANES  = 32;
  localparam int DATA_W = 12;
  localparam int OUT_W  = DATA_W + 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_size = 2'd3;
  logic [LANES*DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic [LANES*OUT_W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic signed [DATA_W-1:0] vec [LANES];

  always #2 clk = ~clk;

  walsh_order_xform #(.LANES(LANES), .DATA_W(DATA_W)) u_walsh_order_xform (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint lane(input int j);
    logic signed [OUT_W-1:0] v;
    v = out_data[j*OUT_W +: OUT_W];
    return longint'(v);
  endfunction

  function automatic int rev_bits(input int v, input int nb);
    int r = 0;
    int t = v;
    for (int b = 0; b < nb; b++) begin
      r = (r << 1) | (t & 1);
      t = t >> 1;
    end
    return r;
  endfunction

  function automatic longint model_lane(input int j, input int code);
    int pts = 4 << code;
    int row;
    longint acc = 0;
    if (j >= pts) return 0;
    row = rev_bits(j ^ (j >> 1), code + 2);
    for (int n = 0; n < pts; n++) begin
      if (($countones(row & n) % 2) == 1) acc -= longint'(vec[n]);
      else acc += longint'(vec[n]);
    end
    return acc;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int code);
    @(negedge clk);
    for (int n = 0; n < LANES; n++) in_data[n*DATA_W +: DATA_W] = vec[n];
    in_size = code[1:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_all(input string req, input int code);
    for (int j = 0; j < LANES; j++) chk(req, $sformatf("lane%0d size%0d", j, code), lane(j), model_lane(j, code));
  endtask

  task automatic t_reset;
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "out_data", longint'(out_data == '0), 1);
  endtask

  task automatic t_random_sizes;
    for (int code = 0; code < 4; code++) begin
      for (int rep = 0; rep < 3; rep++) begin
        for (int n = 0; n < LANES; n++) vec[n] = DATA_W'($urandom);
        drive(code);
        chk("R2", "valid after capture", longint'(out_valid), 1);
        check_all("R6", code);
      end
    end
  endtask

  task automatic t_upper_ignored;
    for (int code = 0; code < 3; code++) begin
      longint ref_l [LANES];
      for (int n = 0; n < LANES; n++) vec[n] = (n < (4 << code)) ? DATA_W'($urandom) : '0;
      drive(code);
      for (int j = 0; j < LANES; j++) ref_l[j] = lane(j);
      for (int n = (4 << code); n < LANES; n++) vec[n] = DATA_W'($urandom | 1);
      drive(code);
      for (int j = 0; j < LANES; j++) begin
        chk("R4", $sformatf("upper inputs lane%0d", j), lane(j), ref_l[j]);
        if (j >= (4 << code)) chk("R5", $sformatf("zero lane%0d", j), lane(j), 0);
      end
    end
  endtask

  task automatic t_hold;
    longint snap [LANES];
    for (int n = 0; n < LANES; n++) vec[n] = DATA_W'($urandom);
    drive(3);
    for (int j = 0; j < LANES; j++) snap[j] = lane(j);
    for (int cyc = 0; cyc < 3; cyc++) begin
      for (int n = 0; n < LANES; n++) in_data[n*DATA_W +: DATA_W] = DATA_W'($urandom);
      in_size = 2'(cyc);
      @(negedge clk);
      chk("R2", "valid low when idle", longint'(out_valid), 0);
      for (int j = 0; j < LANES; j++) chk("R3", $sformatf("hold lane%0d", j), lane(j), snap[j]);
    end
  endtask

  task automatic t_dc;
    for (int code = 0; code < 4; code++) begin
      longint s = 0;
      for (int n = 0; n < LANES; n++) vec[n] = DATA_W'($urandom);
      for (int n = 0; n < (4 << code); n++) s += longint'(vec[n]);
      drive(code);
      chk("R7", $sformatf("dc size%0d", code), lane(0), s);
    end
  endtask

  task automatic t_extremes;
    longint lo = -(longint'(1) << (DATA_W - 1));
    longint hi = (longint'(1) << (DATA_W - 1)) - 1;
    for (int n = 0; n < LANES; n++) vec[n] = DATA_W'(lo);
    drive(3);
    chk("R8", "full negative lane0", lane(0), 32 * lo);
    chk("R8", "full negative lane5", lane(5), 0);
    for (int n = 0; n < LANES; n++) vec[n] = (n % 2 == 0) ? DATA_W'(hi) : DATA_W'(lo);
    drive(3);
    check_all("R8", 3);
    chk("R8", "alternating lane31", lane(31), 16 * (hi - lo));
  endtask

  task automatic t_sequency;
    int sgn [LANES][LANES];
    for (int n = 0; n < LANES; n++) begin
      for (int k = 0; k < LANES; k++) vec[k] = (k == n) ? DATA_W'(1) : '0;
      drive(3);
      for (int j = 0; j < LANES; j++) sgn[j][n] = int'(lane(j));
    end
    for (int j = 0; j < LANES; j++) begin
      int changes = 0;
      for (int n = 1; n < LANES; n++) if (sgn[j][n] != sgn[j][n-1]) changes++;
      chk("R9", $sformatf("sign changes lane%0d", j), changes, j);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_random_sizes();
    t_upper_ignored();
    t_hold();
    t_dc();
    t_extremes();
    t_sequency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule